// File: doc/BRIEF.md
# FIFO Occupancy Busy Monitor

The block watches the fill levels of three groups of readout buffers: the timing-data buffers, the per-source data buffers and the descriptor (management) buffers. Each group has one programmable occupancy limit, and every buffer in that group is compared against it. Any buffer whose level is strictly above its group limit sets its bit in a registered over-limit vector. The OR of that vector drives a single registered busy flag.

Downstream, the output link does not want a level. It wants events. Each time the busy flag changes state, the block issues a single-cycle message toward the link so that triggers are held off upstream until the buffers drain. An activate message marks a rise of the flag and a deactivate message marks a fall. A ready input from the link gates when the message is issued. The block tracks the last state it reported and emits a message only when the live flag differs from that state and the link is ready. If the flag changes and then returns before the link becomes ready, the two changes cancel and no message is sent.

Top module: `fifo_busy_monitor`

## Requirements
- R1: After reset `busy_o` is 0, `over_o` is all zero, and neither `act_o` nor `deact_o` is asserted until the busy flag first changes.
- R2: Each group (timing, source, descriptor) is compared only against its own limit input. A level that is over one group's limit but not over its own group's limit does not mark that buffer.
- R3: The comparison is strictly greater-than. A level equal to its limit does not mark the buffer.
- R4: `busy_o` goes high on the clock edge after any buffer level first exceeds its limit.
- R5: `busy_o` stays high while at least one buffer remains over its limit. It clears on the edge after all levels are at or below their limits.
- R6: `over_o` is registered together with `busy_o`. Bit 0 is the timing buffer, bits 1 to N_SRC are source buffers 0 to N_SRC-1, and the bits above those are descriptor buffers 0 to N_MGT-1.
- R7: When the busy flag has risen since the last report and `msg_rdy_i` is 1, `act_o` is high for exactly one cycle.
- R8: When the busy flag has fallen since the last report and `msg_rdy_i` is 1, `deact_o` is high for exactly one cycle.
- R9: While `msg_rdy_i` is 0, no message is issued and the pending message is held. The message is issued in the first cycle that `msg_rdy_i` is 1.
- R10: If the busy flag returns to the last reported state before the link is ready, no message is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttc_lvl_i | input | N_TTC*LVL_W | Timing buffer levels, packed |
| src_lvl_i | input | N_SRC*LVL_W | Source data buffer levels, packed, buffer 0 in the low bits |
| mgt_lvl_i | input | N_MGT*LVL_W | Descriptor buffer levels, packed, buffer 0 in the low bits |
| ttc_lim_i | input | LVL_W | Limit for timing buffers |
| src_lim_i | input | LVL_W | Limit for source buffers |
| mgt_lim_i | input | LVL_W | Limit for descriptor buffers |
| msg_rdy_i | input | 1 | Output link can take a message this cycle |
| busy_o | output | 1 | Registered busy flag |
| over_o | output | N_TTC+N_SRC+N_MGT | Registered per-buffer over-limit status |
| act_o | output | 1 | Activate message pulse |
| deact_o | output | 1 | Deactivate message pulse |

## Verification
The assertions assume that level and limit inputs are steady across each clock edge and that `msg_rdy_i` changes only between edges. Under that assumption, a message pulse can be tied to the ready signal seen in the same cycle. The bench drives every input on the falling edge and samples a short delay later, so the combinational message outputs already reflect the new ready value. Levels are moved one buffer at a time, or in controlled pairs, so that each transition of the flag is deliberate and can be observed.

// File: rtl/busy_mon_pkg.sv
package busy_mon_pkg;
  typedef enum logic [1:0] {
    MSG_NONE  = 2'd0,
    MSG_ACT   = 2'd1,
    MSG_DEACT = 2'd2
  } msg_e;
endpackage

// File: rtl/busy_group_cmp.sv
module busy_group_cmp #(
  parameter int N     = 4,
  parameter int LVL_W = 8
) (
  input  logic [N*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]   lim_i,
  output logic [N-1:0]       over_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign over_o[g] = lvl_i[g*LVL_W +: LVL_W] > lim_i;
  end
endmodule

// File: rtl/busy_notify.sv
module busy_notify
  import busy_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rdy_i,
  output logic act_o,
  output logic deact_o
);
  logic sent_q;  // last state reported to the link
  msg_e kind;

  always_comb begin
    kind = MSG_NONE;
    if (rdy_i && (busy_i != sent_q)) kind = busy_i ? MSG_ACT : MSG_DEACT;
  end

  assign act_o   = (kind == MSG_ACT);
  assign deact_o = (kind == MSG_DEACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sent_q <= 1'b0;
    else if (rdy_i) sent_q <= busy_i;
  end

  p_act_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |=> !act_o);
  p_deact_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_o |=> !deact_o);
  p_msg_needs_rdy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o || deact_o) |-> rdy_i);
  p_msg_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_o && deact_o));
  p_act_when_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> busy_i);
  p_deact_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_o |-> !busy_i);
endmodule

// File: rtl/fifo_busy_monitor.sv
module fifo_busy_monitor #(
  parameter int N_TTC = 1,
  parameter int N_SRC = 4,
  parameter int N_MGT = 4,
  parameter int LVL_W = 8,
  localparam int N_ALL = N_TTC + N_SRC + N_MGT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_TTC*LVL_W-1:0] ttc_lvl_i,
  input  logic [N_SRC*LVL_W-1:0] src_lvl_i,
  input  logic [N_MGT*LVL_W-1:0] mgt_lvl_i,
  input  logic [LVL_W-1:0]       ttc_lim_i,
  input  logic [LVL_W-1:0]       src_lim_i,
  input  logic [LVL_W-1:0]       mgt_lim_i,
  input  logic                   msg_rdy_i,
  output logic                   busy_o,
  output logic [N_ALL-1:0]       over_o,
  output logic                   act_o,
  output logic                   deact_o
);
  logic [N_TTC-1:0] ttc_over;
  logic [N_SRC-1:0] src_over;
  logic [N_MGT-1:0] mgt_over;
  logic [N_ALL-1:0] over_d;
  logic [N_ALL-1:0] over_q;
  logic             busy_q;

  busy_group_cmp #(.N(N_TTC), .LVL_W(LVL_W)) u_ttc_cmp (
    .lvl_i(ttc_lvl_i), .lim_i(ttc_lim_i), .over_o(ttc_over));
  busy_group_cmp #(.N(N_SRC), .LVL_W(LVL_W)) u_src_cmp (
    .lvl_i(src_lvl_i), .lim_i(src_lim_i), .over_o(src_over));
  busy_group_cmp #(.N(N_MGT), .LVL_W(LVL_W)) u_mgt_cmp (
    .lvl_i(mgt_lvl_i), .lim_i(mgt_lim_i), .over_o(mgt_over));

  assign over_d = {mgt_over, src_over, ttc_over};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q <= '0;
      busy_q <= 1'b0;
    end else begin
      over_q <= over_d;
      busy_q <= |over_d;
    end
  end

  assign over_o = over_q;
  assign busy_o = busy_q;

  busy_notify u_notify (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_q),
    .rdy_i  (msg_rdy_i),
    .act_o  (act_o),
    .deact_o(deact_o)
  );

  p_busy_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|over_d) |=> busy_o);
  p_busy_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|over_d) |=> !busy_o);
  p_equal_not_over_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_lvl_i[LVL_W-1:0] == src_lim_i) |=> !over_o[N_TTC]);
  p_ttc_own_lim_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ttc_lvl_i[LVL_W-1:0] <= ttc_lim_i) |=> !over_o[0]);
endmodule

// File: tb/fifo_busy_monitor_bench.sv
module fifo_busy_monitor_bench;
  localparam int N_TTC = 1, N_SRC = 4, N_MGT = 4, LVL_W = 8;
  localparam int N_ALL = N_TTC + N_SRC + N_MGT;

  logic clk = 0, rst_n = 0;
  logic [LVL_W-1:0] ttc_l [N_TTC];
  logic [LVL_W-1:0] src_l [N_SRC];
  logic [LVL_W-1:0] mgt_l [N_MGT];
  logic [N_TTC*LVL_W-1:0] ttc_p;
  logic [N_SRC*LVL_W-1:0] src_p;
  logic [N_MGT*LVL_W-1:0] mgt_p;
  logic [LVL_W-1:0] ttc_lim, src_lim, mgt_lim;
  logic rdy;
  logic busy, act, deact;
  logic [N_ALL-1:0] over;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N_TTC; i++) ttc_p[i*LVL_W +: LVL_W] = ttc_l[i];
    for (int i = 0; i < N_SRC; i++) src_p[i*LVL_W +: LVL_W] = src_l[i];
    for (int i = 0; i < N_MGT; i++) mgt_p[i*LVL_W +: LVL_W] = mgt_l[i];
  end

  fifo_busy_monitor #(.N_TTC(N_TTC), .N_SRC(N_SRC), .N_MGT(N_MGT), .LVL_W(LVL_W))
  u_fifo_busy_monitor (
    .clk_i(clk), .rst_ni(rst_n), .ttc_lvl_i(ttc_p), .src_lvl_i(src_p),
    .mgt_lvl_i(mgt_p), .ttc_lim_i(ttc_lim), .src_lim_i(src_lim),
    .mgt_lim_i(mgt_lim), .msg_rdy_i(rdy), .busy_o(busy), .over_o(over),
    .act_o(act), .deact_o(deact));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N_TTC; i++) ttc_l[i] = '0;
    for (int i = 0; i < N_SRC; i++) src_l[i] = '0;
    for (int i = 0; i < N_MGT; i++) mgt_l[i] = '0;
    rdy = 1'b1;
    tick(); tick();
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 over", over, 0);
    chk("R1 act", act, 0);   chk("R1 deact", deact, 0);
    tick();
    chk("R1 no msg after idle", {act, deact}, 0);
  endtask

  task automatic t_equal_and_edges();
    src_l[2] = 8'd10; tick();
    chk("R3 equal not over", over, 0); chk("R3 equal not busy", busy, 0);
    src_l[2] = 8'd11; tick();
    chk("R4 busy set", busy, 1);
    chk("R6 src2 bit", over, 32'(1) << (N_TTC + 2));
    chk("R7 act pulse", act, 1); chk("R7 no deact", deact, 0);
    tick();
    chk("R7 act one cycle", act, 0); chk("R5 busy held", busy, 1);
    src_l[2] = 8'd10; tick();
    chk("R5 busy cleared", busy, 0); chk("R8 deact pulse", deact, 1);
    tick();
    chk("R8 deact one cycle", deact, 0);
    clear_all();
  endtask

  task automatic t_own_limits();
    ttc_l[0] = 8'd20; mgt_l[1] = 8'd20; tick();
    chk("R2 ttc under own limit", over[0], 0);
    chk("R6 mgt1 bit", over, 32'(1) << (N_TTC + N_SRC + 1));
    chk("R2 busy", busy, 1);
    ttc_l[0] = 8'd51; tick();
    chk("R6 ttc bit0", over[0], 1);
    clear_all();
    chk("R2 cleared", busy, 0);
  endtask

  task automatic t_multi();
    src_l[0] = 8'd99; mgt_l[3] = 8'd99; tick();
    chk("R4 two over", busy, 1); chk("R7 single act", act, 1);
    src_l[0] = 8'd0; tick();
    chk("R5 one still over", busy, 1); chk("R5 no deact", deact, 0);
    chk("R6 mgt3 bit", over, 32'(1) << (N_TTC + N_SRC + 3));
    mgt_l[3] = 8'd5; tick();
    chk("R5 all at limit", busy, 0); chk("R8 deact", deact, 1);
    clear_all();
  endtask

  task automatic t_ready_hold();
    rdy = 1'b0; ttc_l[0] = 8'd60; tick();
    chk("R9 busy", busy, 1); chk("R9 act held", act, 0);
    tick();
    chk("R9 still held", act, 0);
    rdy = 1'b1; #1;
    chk("R9 act on ready", act, 1);
    tick();
    chk("R9 act one cycle", act, 0);
    clear_all();
  endtask

  task automatic t_revert();
    rdy = 1'b0; src_l[3] = 8'd200; tick();
    chk("R10 busy up", busy, 1);
    src_l[3] = 8'd0; tick();
    chk("R10 busy down", busy, 0);
    rdy = 1'b1; #1;
    chk("R10 no act", act, 0); chk("R10 no deact", deact, 0);
    tick();
    chk("R10 still silent", {act, deact}, 0);
  endtask

  initial begin
    ttc_lim = 8'd50; src_lim = 8'd10; mgt_lim = 8'd5; rdy = 1'b1;
    for (int i = 0; i < N_TTC; i++) ttc_l[i] = '0;
    for (int i = 0; i < N_SRC; i++) src_l[i] = '0;
    for (int i = 0; i < N_MGT; i++) mgt_l[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset();
    t_equal_and_edges();
    t_own_limits();
    t_multi();
    t_ready_hold();
    t_revert();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule